// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block sits beside the execute stage of a 32-bit core whose instructions are one word each. Each cycle it receives the address of the current instruction, the instruction word, a control-flow class chosen by the decoder, the values of the two source registers, and the current interrupt-enable state. From these it works out four things: the address of the next instruction, whether control flow was redirected, whether a link value must be written to the return-address register, and the new interrupt-enable state.

The unit covers six conditional compare-and-branch forms, a relative jump with a long immediate, a relative call with a long immediate, a call through a register, and a jump through a register. A jump through the exception-return or breakpoint-return register also restores the global interrupt enable from the copy saved on entry to the handler. All results are registered together on one clock edge. This means the new program counter and the new interrupt-enable state become visible in the same cycle. Fetch redirection and pipeline flushing are handled by the blocks that consume these outputs.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `next_pc`, `link_data` and `ie_out` read zero, and `taken` and `link_we` read zero.
- R2: Conditional classes on `op_class` are 1 equal, 2 not equal, 3 signed greater, 4 signed greater-or-equal, 5 unsigned greater, 6 unsigned greater-or-equal. Each compares `rs_a` (the register named by `insn[25:21]`) against `rs_b` (the register named by `insn[20:16]`). When the condition holds, `taken` is 1 and `next_pc` is `pc` plus `insn[15:0]` shifted left by two and sign-extended from 18 bits.
- R3: For a conditional class whose condition is false, and for classes 0 and 11 to 15 (no control flow), `taken` is 0 and `next_pc` is `pc + 4`.
- R4: Class 7 (relative jump) and class 8 (relative call) set `taken` and make `next_pc` equal `pc` plus `insn[25:0]` shifted left by two and sign-extended from 28 bits.
- R5: Classes 8 and 9 (the calls) assert `link_we`, and `link_data` carries `pc + 4`; `link_idx` always reads 29. No other class asserts `link_we`.
- R6: Class 9 (register call) and class 10 (register jump) set `taken` and make `next_pc` equal `rs_a`.
- R7: Class 10 with `insn[25:21]` equal to 30 sets `ie_out[0]` to `ie_in[1]`. The interrupt-enable bit layout is: bit 0 global enable, bit 1 saved copy for exceptions, bit 2 saved copy for breakpoints.
- R8: Class 10 with `insn[25:21]` equal to 31 sets `ie_out[0]` to `ie_in[2]`. In every other case `ie_out` equals `ie_in`. Bits 2:1 always pass through unchanged.
- R9: The two low bits of `next_pc` and of `link_data` are always zero, whatever the low bits of `pc`, `rs_a` or the offset sum.
- R10: Outputs change only on the rising clock edge that samples the inputs. A change of inputs between edges leaves them unchanged, and all outputs for one instruction appear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc | input | 32 | Address of the current instruction |
| insn | input | 32 | Current instruction word (register and immediate fields) |
| op_class | input | 4 | Control-flow class from the decoder |
| rs_a | input | 32 | Value of the register at `insn[25:21]` |
| rs_b | input | 32 | Value of the register at `insn[20:16]` |
| ie_in | input | 3 | Current interrupt-enable state |
| next_pc | output | 32 | Registered address of the next instruction |
| taken | output | 1 | Registered redirect flag |
| link_we | output | 1 | Registered write enable for the return-address register |
| link_idx | output | 5 | Index of the return-address register |
| link_data | output | 32 | Registered link value |
| ie_out | output | 3 | Registered interrupt-enable state |

## Verification
A defect in the comparator or the decode of the conditional classes shows up as the wrong `taken` value and the wrong `next_pc` one cycle after the instruction is presented. Signed and unsigned errors appear only on operands whose top bits differ, so those operands are forced often. A wrong return-register match or a wrong saved-bit selection appears as a bad `ie_out[0]` in that same cycle. Sign-extension errors in either offset appear only with negative immediates, so those are targeted directly.

// File: rtl/npc_pkg.sv
package npc_pkg;

    parameter int unsigned NPC_XLEN  = 32;
    parameter int unsigned NPC_RIDX  = 5;
    parameter int unsigned NPC_IEW   = 3;

    typedef enum logic [3:0] {
        OPC_NONE = 4'd0,
        OPC_BEQ  = 4'd1,
        OPC_BNE  = 4'd2,
        OPC_BGT  = 4'd3,
        OPC_BGE  = 4'd4,
        OPC_BGTU = 4'd5,
        OPC_BGEU = 4'd6,
        OPC_JIMM = 4'd7,
        OPC_CIMM = 4'd8,
        OPC_CREG = 4'd9,
        OPC_JREG = 4'd10
    } npc_op_e;

    typedef struct packed {
        logic [NPC_XLEN-1:0] next_pc;
        logic                taken;
        logic                link_we;
        logic [NPC_XLEN-1:0] link_data;
        logic [NPC_IEW-1:0]  ie;
    } npc_state_t;

endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval #(
    parameter int unsigned W = 32
) (
    input  logic [3:0]   sel,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic         is_cond,
    output logic         hit
);
    import npc_pkg::*;

    logic eq_w;
    logic sgt_w;
    logic ugt_w;

    assign eq_w  = (lhs == rhs);
    assign sgt_w = ($signed(lhs) > $signed(rhs));
    assign ugt_w = (lhs > rhs);

    always_comb begin
        is_cond = 1'b1;
        hit     = 1'b0;
        case (npc_op_e'(sel))
            OPC_BEQ:  hit = eq_w;
            OPC_BNE:  hit = !eq_w;
            OPC_BGT:  hit = sgt_w;
            OPC_BGE:  hit = sgt_w | eq_w;
            OPC_BGTU: hit = ugt_w;
            OPC_BGEU: hit = ugt_w | eq_w;
            default:  is_cond = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
    parameter int unsigned W      = 32,
    parameter int unsigned SHORT_W = 16,
    parameter int unsigned LONG_W  = 26
) (
    input  logic [W-1:0]       pc,
    input  logic [SHORT_W-1:0] imm_short,
    input  logic [LONG_W-1:0]  imm_long,
    input  logic [W-1:0]       reg_val,
    output logic [W-1:0]       seq_tgt,
    output logic [W-1:0]       short_tgt,
    output logic [W-1:0]       long_tgt,
    output logic [W-1:0]       reg_tgt
);
    localparam int unsigned SHORT_EXT = W - SHORT_W - 2;
    localparam int unsigned LONG_EXT  = W - LONG_W - 2;
    localparam logic [W-1:0] ALIGN_MASK = ~{{(W-2){1'b0}}, 2'b11};
    localparam logic [W-1:0] WORD_STEP  = W'(4);

    logic [W-1:0] pc_base;
    logic [W-1:0] short_off;
    logic [W-1:0] long_off;

    assign pc_base   = pc & ALIGN_MASK;
    assign short_off = {{SHORT_EXT{imm_short[SHORT_W-1]}}, imm_short, 2'b00};
    assign long_off  = {{LONG_EXT{imm_long[LONG_W-1]}}, imm_long, 2'b00};

    assign seq_tgt   = pc_base + WORD_STEP;
    assign short_tgt = (pc_base + short_off) & ALIGN_MASK;
    assign long_tgt  = (pc_base + long_off) & ALIGN_MASK;
    assign reg_tgt   = reg_val & ALIGN_MASK;

endmodule

// File: rtl/npc_ie_restore.sv
module npc_ie_restore #(
    parameter int unsigned RIDX   = 5,
    parameter int unsigned EA_IDX = 30,
    parameter int unsigned BA_IDX = 31
) (
    input  logic            is_jreg,
    input  logic [RIDX-1:0] jreg_idx,
    input  logic [2:0]      ie_in,
    output logic [2:0]      ie_out
);
    localparam int unsigned NRET = 2;

    logic [NRET-1:0] match;
    logic [NRET-1:0] saved;

    for (genvar g = 0; g < NRET; g++) begin : g_ret
        localparam int unsigned IDX = (g == 0) ? EA_IDX : BA_IDX;
        assign match[g] = is_jreg && (jreg_idx == RIDX'(IDX));
        assign saved[g] = ie_in[g+1];
    end

    always_comb begin
        ie_out = ie_in;
        for (int k = 0; k < NRET; k++) begin
            if (match[k]) begin
                ie_out[0] = saved[k];
            end
        end
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int unsigned LINK_IDX = 29,
    parameter int unsigned EA_IDX   = 30,
    parameter int unsigned BA_IDX   = 31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPC_XLEN-1:0] pc,
    input  logic [31:0]         insn,
    input  logic [3:0]          op_class,
    input  logic [NPC_XLEN-1:0] rs_a,
    input  logic [NPC_XLEN-1:0] rs_b,
    input  logic [NPC_IEW-1:0]  ie_in,
    output logic [NPC_XLEN-1:0] next_pc,
    output logic                taken,
    output logic                link_we,
    output logic [NPC_RIDX-1:0] link_idx,
    output logic [NPC_XLEN-1:0] link_data,
    output logic [NPC_IEW-1:0]  ie_out
);
    localparam int unsigned SHORT_W = 16;
    localparam int unsigned LONG_W  = 26;

    npc_state_t st_d;
    npc_state_t st_q;

    logic                is_cond;
    logic                cond_hit;
    logic [NPC_XLEN-1:0] seq_tgt;
    logic [NPC_XLEN-1:0] short_tgt;
    logic [NPC_XLEN-1:0] long_tgt;
    logic [NPC_XLEN-1:0] reg_tgt;
    logic [NPC_IEW-1:0]  ie_new;
    logic                is_jreg;

    assign is_jreg = (npc_op_e'(op_class) == OPC_JREG);

    npc_cond_eval #(.W(NPC_XLEN)) u_cond (
        .sel     (op_class),
        .lhs     (rs_a),
        .rhs     (rs_b),
        .is_cond (is_cond),
        .hit     (cond_hit)
    );

    npc_target_gen #(.W(NPC_XLEN), .SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_tgt (
        .pc        (pc),
        .imm_short (insn[SHORT_W-1:0]),
        .imm_long  (insn[LONG_W-1:0]),
        .reg_val   (rs_a),
        .seq_tgt   (seq_tgt),
        .short_tgt (short_tgt),
        .long_tgt  (long_tgt),
        .reg_tgt   (reg_tgt)
    );

    npc_ie_restore #(.RIDX(NPC_RIDX), .EA_IDX(EA_IDX), .BA_IDX(BA_IDX)) u_ie (
        .is_jreg  (is_jreg),
        .jreg_idx (insn[25:21]),
        .ie_in    (ie_in),
        .ie_out   (ie_new)
    );

    always_comb begin
        st_d           = '0;
        st_d.next_pc   = seq_tgt;
        st_d.link_data = seq_tgt;
        st_d.ie        = ie_new;
        if (is_cond) begin
            if (cond_hit) begin
                st_d.next_pc = short_tgt;
                st_d.taken   = 1'b1;
            end
        end else begin
            case (npc_op_e'(op_class))
                OPC_JIMM: begin
                    st_d.next_pc = long_tgt;
                    st_d.taken   = 1'b1;
                end
                OPC_CIMM: begin
                    st_d.next_pc = long_tgt;
                    st_d.taken   = 1'b1;
                    st_d.link_we = 1'b1;
                end
                OPC_CREG: begin
                    st_d.next_pc = reg_tgt;
                    st_d.taken   = 1'b1;
                    st_d.link_we = 1'b1;
                end
                OPC_JREG: begin
                    st_d.next_pc = reg_tgt;
                    st_d.taken   = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign next_pc   = st_q.next_pc;
    assign taken     = st_q.taken;
    assign link_we   = st_q.link_we;
    assign link_data = st_q.link_data;
    assign ie_out    = st_q.ie;
    assign link_idx  = NPC_RIDX'(LINK_IDX);

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc,
    input logic [31:0] insn,
    input logic [3:0]  op_class,
    input logic [2:0]  ie_in,
    input logic [31:0] next_pc,
    input logic        taken,
    input logic        link_we,
    input logic [31:0] link_data,
    input logic [2:0]  ie_out
);
    logic armed;

    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        next_pc[1:0] == 2'b00);                                              // R9

    AST_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !taken) |-> (next_pc == (($past(pc) & ~32'd3) + 32'd4)));  // R3

    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && link_we) |-> (link_data == (($past(pc) & ~32'd3) + 32'd4))); // R5

    AST_LINK_ONLY_CALL: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && link_we) |-> ($past(op_class) == 4'd8 || $past(op_class) == 4'd9)); // R5

    AST_SAVED_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (ie_out[2:1] == $past(ie_in[2:1])));                       // R8

    AST_IE_NONRET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_class) != 4'd10) |-> (ie_out == $past(ie_in)));   // R8

    AST_EXC_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_class) == 4'd10 && $past(insn[25:21]) == 5'd30)
        |-> (ie_out[0] == $past(ie_in[1])));                                 // R7

    AST_UNCOND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_class) >= 4'd7 && $past(op_class) <= 4'd10) |-> taken); // R4

endmodule

bind npc_unit npc_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc        (pc),
    .insn      (insn),
    .op_class  (op_class),
    .ie_in     (ie_in),
    .next_pc   (next_pc),
    .taken     (taken),
    .link_we   (link_we),
    .link_data (link_data),
    .ie_out    (ie_out)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc = '0;
    logic [31:0] insn = '0;
    logic [3:0]  op_class = '0;
    logic [31:0] rs_a = '0;
    logic [31:0] rs_b = '0;
    logic [2:0]  ie_in = '0;
    logic [31:0] next_pc;
    logic        taken;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_data;
    logic [2:0]  ie_out;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    npc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .pc(pc), .insn(insn), .op_class(op_class),
        .rs_a(rs_a), .rs_b(rs_b), .ie_in(ie_in), .next_pc(next_pc),
        .taken(taken), .link_we(link_we), .link_idx(link_idx),
        .link_data(link_data), .ie_out(ie_out)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] seq_of(input logic [31:0] p);
        return {p[31:2], 2'b00} + 32'd4;
    endfunction

    function automatic logic cond_of(input logic [3:0] op,
                                     input logic [31:0] a, input logic [31:0] b);
        case (op)
            4'd1: return a == b;
            4'd2: return a != b;
            4'd3: return $signed(a) > $signed(b);
            4'd4: return $signed(a) >= $signed(b);
            4'd5: return a > b;
            4'd6: return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    task automatic apply(input logic [31:0] p, input logic [31:0] w,
                         input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [2:0] ie);
        logic [31:0] base, e_pc, e_ld;
        logic        e_tk, e_lw;
        logic [2:0]  e_ie;
        string       t_pc, t_ie;
        base = {p[31:2], 2'b00};
        e_ld = seq_of(p);
        e_pc = e_ld; e_tk = 1'b0; e_lw = 1'b0; e_ie = ie;
        t_pc = "R3"; t_ie = "R8";
        if (op >= 4'd1 && op <= 4'd6) begin
            if (cond_of(op, a, b)) begin
                e_tk = 1'b1; t_pc = "R2";
                e_pc = base + {{14{w[15]}}, w[15:0], 2'b00};
            end
        end else if (op == 4'd7 || op == 4'd8) begin
            e_tk = 1'b1; t_pc = "R4";
            e_pc = base + {{4{w[25]}}, w[25:0], 2'b00};
            e_lw = (op == 4'd8);
        end else if (op == 4'd9 || op == 4'd10) begin
            e_tk = 1'b1; t_pc = "R6";
            e_pc = {a[31:2], 2'b00};
            e_lw = (op == 4'd9);
            if (op == 4'd10 && w[25:21] == 5'd30) begin e_ie[0] = ie[1]; t_ie = "R7"; end
            if (op == 4'd10 && w[25:21] == 5'd31) begin e_ie[0] = ie[2]; t_ie = "R8"; end
        end
        pc = p; insn = w; op_class = op; rs_a = a; rs_b = b; ie_in = ie;
        @(posedge clk);
        @(negedge clk);
        chk(t_pc, "next_pc", next_pc, e_pc);
        chk(t_pc, "taken", {31'd0, taken}, {31'd0, e_tk});
        chk("R5", "link_we", {31'd0, link_we}, {31'd0, e_lw});
        if (e_lw) chk("R5", "link_data", link_data, e_ld);
        chk(t_ie, "ie_out", {29'd0, ie_out}, {29'd0, e_ie});
        chk("R9", "low bits", {30'd0, next_pc[1:0]}, 32'd0);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        pc = 32'h1234_5678; op_class = 4'd8; ie_in = 3'b111;
        @(negedge clk);
        // R1: reset state
        chk("R1", "next_pc", next_pc, 32'd0);
        chk("R1", "flags", {29'd0, taken, link_we, 1'b0}, 32'd0);
        chk("R1", "ie_out", {29'd0, ie_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "link_idx", {27'd0, link_idx}, 32'd29);

        // R2 signed vs unsigned at top-bit boundary
        apply(32'h100, 32'h0000_FFFF, 4'd3, 32'h8000_0000, 32'd1, 3'b000);
        apply(32'h100, 32'h0000_FFFF, 4'd5, 32'h8000_0000, 32'd1, 3'b000);
        apply(32'h100, 32'h0000_8000, 4'd4, 32'd7, 32'd7, 3'b000);
        apply(32'h100, 32'h0000_0010, 4'd6, 32'd6, 32'd7, 3'b000);
        apply(32'h100, 32'h0000_0010, 4'd1, 32'd5, 32'd5, 3'b000);
        apply(32'h100, 32'h0000_0010, 4'd2, 32'd5, 32'd5, 3'b000);
        // R4 negative long offset, wrap
        apply(32'h0000_0008, 32'h03FF_FFFE, 4'd7, 32'd0, 32'd0, 3'b010);
        apply(32'hFFFF_FFFC, 32'h0000_0001, 4'd8, 32'd0, 32'd0, 3'b010);
        // R6/R7/R8 returns with misaligned register value
        apply(32'h200, {6'd0, 5'd30, 21'd0}, 4'd10, 32'h0000_4003, 32'd0, 3'b010);
        apply(32'h200, {6'd0, 5'd30, 21'd0}, 4'd10, 32'h0000_4003, 32'd0, 3'b101);
        apply(32'h200, {6'd0, 5'd31, 21'd0}, 4'd10, 32'h0000_4001, 32'd0, 3'b100);
        apply(32'h200, {6'd0, 5'd31, 21'd0}, 4'd10, 32'h0000_4001, 32'd0, 3'b011);
        apply(32'h200, {6'd0, 5'd29, 21'd0}, 4'd10, 32'h0000_4000, 32'd0, 3'b110);
        apply(32'h203, {6'd0, 5'd30, 21'd0}, 4'd9, 32'h0000_8002, 32'd0, 3'b010);
        apply(32'h203, 32'd0, 4'd13, 32'd0, 32'd0, 3'b001);

        // R10: inputs change between edges, outputs hold
        apply(32'h300, 32'd0, 4'd7, 32'd0, 32'd0, 3'b000);
        op_class = 4'd0; pc = 32'h500;
        #1;
        chk("R10", "hold next_pc", next_pc, 32'h300);
        chk("R10", "hold taken", {31'd0, taken}, 32'd1);

        for (int i = 0; i < 1500; i++) begin
            logic [31:0] p, w, a, b;
            logic [3:0]  op;
            p  = $urandom();
            w  = $urandom();
            op = 4'($urandom_range(0, 15));
            a  = $urandom();
            b  = ($urandom_range(0, 3) == 0) ? a : $urandom();
            if ($urandom_range(0, 3) == 0) b = b ^ 32'h8000_0000;
            if (op == 4'd10) w[25:21] = 5'(29 + $urandom_range(0, 2));
            apply(p, w, op, a, b, 3'($urandom()));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule